// File: doc/BRIEF.md
# Refresh Hold-Off After Processor Pause

This block tells a dynamic-memory refresh controller when it must not start a hidden refresh. After the processor comes out of a pause, its first memory cycle can arrive at any moment. A refresh that starts in that window would collide with it. The block watches the events that end a pause and raises one hold-off output, `refresh_inhibit`.

There are two ways the output is held. The first is a wait-exit latch. A rising edge on either ready line sets it, and it stays set until the processor's next memory-cycle start pulse or an explicit clear. The second is a retriggerable timer counted in clock cycles. The trailing (falling) edge of any of these lines starts it:
- halt-acknowledge;
- power-on clear;
- the front-panel reset, but only when a strap input allows it.

The output is the OR of the latch and the running timer.

All event inputs are asynchronous. Each one passes through a multi-flop synchronizer before its edge is detected, so a metastable sample cannot create a false event. This costs a few clock cycles of delay.

Top module: `refresh_holdoff`

## Requirements
- R1: While `rst_n` is low, and after it is released with no event on any input, `refresh_inhibit` is 0.
- R2: A 0-to-1 change on `rdy_main` sets the wait-exit latch. `refresh_inhibit` becomes 1 after the (SYNC_STAGES+1)-th rising clock edge that follows the change, and it stays 1 while the latch is set.
- R3: A 0-to-1 change on `rdy_aux` sets the same latch, with the same delay as R2.
- R4: A `cycle_start` pulse that is high at a rising clock edge clears a set latch at that edge. A pulse while the latch is clear changes nothing.
- R5: `wait_clr` high at a clock edge clears the latch. If a ready edge is detected at the same edge, the clear wins.
- R6: A 1-to-0 change on `halt_ack` makes `refresh_inhibit` 1 for exactly HOLD_CYCLES clock cycles, starting with the same delay as R2. A 0-to-1 change on `halt_ack` has no effect.
- R7: A 1-to-0 change on `poc` starts the same timer as R6, with the same delay and length.
- R8: A 1-to-0 change on `panel_rst` starts the timer only when `panel_rst_en` is 1. When `panel_rst_en` is 0, that change has no effect.
- R9: An event that arrives while the timer is running restarts the full HOLD_CYCLES count from the edge where the event is detected.
- R10: `refresh_inhibit` is 1 whenever the latch is set or the timer is running. Clearing the latch does not end a timer period that is still running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| wait_clr | input | 1 | Synchronous clear of the wait-exit latch |
| rdy_main | input | 1 | Primary ready line, asynchronous |
| rdy_aux | input | 1 | Auxiliary ready line, asynchronous |
| halt_ack | input | 1 | Halt-acknowledge line, asynchronous |
| poc | input | 1 | Power-on clear, asynchronous |
| panel_rst | input | 1 | Front-panel reset, asynchronous |
| panel_rst_en | input | 1 | Strap input that lets the panel reset start the timer; held static |
| cycle_start | input | 1 | Synchronous pulse marking the start of a processor memory cycle |
| refresh_inhibit | output | 1 | High while refresh cycles must be held off |

## Verification
The assertions check the following on every cycle:
- the latch's priorities: the clear wins over a set, a set takes effect, and a memory-cycle start ends a set latch;
- the timer reloads on every trigger and counts down one per cycle;
- a panel-reset edge with the strap low cannot start the timer;
- the output never rises unless an edge was detected one cycle earlier.

Only the bench's scenarios can show the end-to-end behaviour:
- the exact synchronizer delay, counted from the input pin;
- the exact length of the hold period;
- that a rising halt edge is ignored;
- that a trigger in mid-period extends the hold;
- that the latch and the timer overlap correctly in the output.

// File: rtl/refinh_pkg.sv
`timescale 1ns/1ps
package refinh_pkg;

   // Which transition of a synchronized input raises the event strobe
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_ANY  = 2'd2
   } edge_sel_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/refinh_sync.sv
`timescale 1ns/1ps
module refinh_sync #(
   parameter int unsigned          STAGES = 2,
   parameter refinh_pkg::edge_sel_e EDGE  = refinh_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic evt
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < refinh_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("refinh_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   // Shift register: chain[0] may go metastable, chain[LAST] is clean
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[LAST];
      end
   end

   if (EDGE == refinh_pkg::EDGE_RISE) begin : g_rise
      assign evt = chain[LAST] & ~prev;
   end else if (EDGE == refinh_pkg::EDGE_FALL) begin : g_fall
      assign evt = ~chain[LAST] & prev;
   end else begin : g_any
      assign evt = chain[LAST] ^ prev;
   end

endmodule

// File: rtl/refinh_wait_latch.sv
`timescale 1ns/1ps
module refinh_wait_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set_evt,
   input  logic cyc_start,
   output logic held
);

   // Priority: explicit clear, then a new ready edge, then cycle start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= 1'b0;
      else if (clr)
         held <= 1'b0;
      else if (set_evt)
         held <= 1'b1;
      else if (cyc_start)
         held <= 1'b0;
   end

   a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !held);

   a_r2_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt && !clr) |=> held);

   a_r4_cycle_ends_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (held && cyc_start && !set_evt && !clr) |=> !held);

endmodule

// File: rtl/refinh_oneshot.sv
`timescale 1ns/1ps
module refinh_oneshot #(
   parameter int unsigned HOLD  = 750,
   parameter int unsigned CNT_W = $clog2(HOLD + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active
);

   if (HOLD < 1) begin : g_bad_hold
      $error("refinh_oneshot: HOLD must be at least 1");
   end
   if (HOLD >= (64'd1 << CNT_W)) begin : g_bad_width
      $error("refinh_oneshot: CNT_W too narrow for HOLD");
   end

   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   // Retriggerable: any fire reloads the full period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (fire)
         cnt <= LOAD;
      else if (cnt != '0)
         cnt <= cnt - ONE;
   end

   assign active = (cnt != '0);

   a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == LOAD));

   a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !fire) |=> (cnt == $past(cnt) - ONE));

   a_r6_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !fire) |=> !active);

endmodule

// File: rtl/refresh_holdoff.sv
`timescale 1ns/1ps
module refresh_holdoff #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYCLES = 750,
   parameter int unsigned CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_clr,
   input  logic rdy_main,
   input  logic rdy_aux,
   input  logic halt_ack,
   input  logic poc,
   input  logic panel_rst,
   input  logic panel_rst_en,
   input  logic cycle_start,
   output logic refresh_inhibit
);

   localparam int unsigned N_RDY  = 2;
   localparam int unsigned N_EXIT = 3;
   localparam int unsigned IX_HALT  = 0;
   localparam int unsigned IX_POC   = 1;
   localparam int unsigned IX_PANEL = 2;

   logic [N_RDY-1:0]  rdy_raw, rdy_evt;
   logic [N_EXIT-1:0] exit_raw, exit_evt;
   logic              wait_held, timer_active, fire, any_evt;

   assign rdy_raw  = {rdy_aux, rdy_main};
   assign exit_raw = {panel_rst, poc, halt_ack};

   // Leading edges of the ready lines
   for (genvar gi = 0; gi < N_RDY; gi++) begin : g_rdy
      refinh_sync #(
         .STAGES (SYNC_STAGES),
         .EDGE   (refinh_pkg::EDGE_RISE)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (rdy_raw[gi]),
         .evt   (rdy_evt[gi])
      );
   end

   // Trailing edges of halt, power-on clear and panel reset
   for (genvar gj = 0; gj < N_EXIT; gj++) begin : g_exit
      refinh_sync #(
         .STAGES (SYNC_STAGES),
         .EDGE   (refinh_pkg::EDGE_FALL)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (exit_raw[gj]),
         .evt   (exit_evt[gj])
      );
   end

   refinh_wait_latch u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (wait_clr),
      .set_evt   (|rdy_evt),
      .cyc_start (cycle_start),
      .held      (wait_held)
   );

   assign fire = exit_evt[IX_HALT] | exit_evt[IX_POC]
               | (exit_evt[IX_PANEL] & panel_rst_en);

   refinh_oneshot #(
      .HOLD  (HOLD_CYCLES),
      .CNT_W (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .active (timer_active)
   );

   assign refresh_inhibit = wait_held | timer_active;

   assign any_evt = (|rdy_evt) | (|exit_evt);

   a_r10_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refresh_inhibit) |-> $past(any_evt));

   a_r8_strap_blocks_panel: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_evt[IX_PANEL] && !panel_rst_en && !exit_evt[IX_HALT]
       && !exit_evt[IX_POC] && !timer_active) |=> !timer_active);

endmodule

// File: tb/sim_refresh_holdoff.sv
`timescale 1ns/1ps
module sim_refresh_holdoff;

   localparam int HOLD = 16;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wait_clr = 1'b0, rdy_main = 1'b0, rdy_aux = 1'b0;
   logic halt_ack = 1'b0, poc = 1'b1, panel_rst = 1'b0;
   logic panel_rst_en = 1'b0, cycle_start = 1'b0;
   logic refresh_inhibit;

   always #2 clk = ~clk;

   refresh_holdoff #(
      .SYNC_STAGES (SYNC),
      .HOLD_CYCLES (HOLD)
   ) u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .wait_clr        (wait_clr),
      .rdy_main        (rdy_main),
      .rdy_aux         (rdy_aux),
      .halt_ack        (halt_ack),
      .poc             (poc),
      .panel_rst       (panel_rst),
      .panel_rst_en    (panel_rst_en),
      .cycle_start     (cycle_start),
      .refresh_inhibit (refresh_inhibit)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   int    q_at[$];
   bit    q_val[$];
   string q_tag[$];

   // Driver side: queue an expected output value for a given cycle
   task automatic expect_at(int at, bit v, string tag);
      q_at.push_back(at);
      q_val.push_back(v);
      q_tag.push_back(tag);
   endtask

   // Monitor side: compare at the falling edge of the scheduled cycle
   always @(negedge clk) begin
      while (q_at.size() > 0 && q_at[0] <= cyc) begin
         checks++;
         if (q_at[0] < cyc) begin
            errors++;
            $display("FAIL %s: check for cycle %0d missed at cycle %0d (actual n/a, expected %b)",
                     q_tag[0], q_at[0], cyc, q_val[0]);
         end else if (refresh_inhibit !== q_val[0]) begin
            errors++;
            $display("FAIL %s: cycle %0d refresh_inhibit actual %b expected %b",
                     q_tag[0], cyc, refresh_inhibit, q_val[0]);
         end
         void'(q_at.pop_front());
         void'(q_val.pop_front());
         void'(q_tag.pop_front());
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      while (q_at.size() > 0) @(negedge clk);
      step(2);
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      finish_run();
   end

   initial begin
      int c;
      // R1: quiet during and after reset
      expect_at(1, 1'b0, "R1");
      expect_at(2, 1'b0, "R1");
      step(3);
      rst_n = 1'b1;
      c = cyc;
      expect_at(c + 2, 1'b0, "R1");
      expect_at(c + 6, 1'b0, "R1");
      drain();

      // R2: primary ready leading edge sets latch
      c = cyc;
      rdy_main = 1'b1;
      expect_at(c + LAT - 1, 1'b0, "R2");
      expect_at(c + LAT, 1'b1, "R2");
      expect_at(c + LAT + 10, 1'b1, "R2");
      drain();
      rdy_main = 1'b0;
      step(4);
      // R4: memory-cycle start ends the latch
      c = cyc;
      expect_at(c + 1, 1'b1, "R4");
      expect_at(c + 2, 1'b0, "R4");
      step(1);
      cycle_start = 1'b1;
      step(1);
      cycle_start = 1'b0;
      drain();
      // R4: pulse with latch clear has no effect
      c = cyc;
      cycle_start = 1'b1;
      expect_at(c + 2, 1'b0, "R4");
      expect_at(c + 5, 1'b0, "R4");
      step(1);
      cycle_start = 1'b0;
      drain();

      // R3: auxiliary ready, then R5 clear
      c = cyc;
      rdy_aux = 1'b1;
      expect_at(c + LAT - 1, 1'b0, "R3");
      expect_at(c + LAT, 1'b1, "R3");
      expect_at(c + LAT + 6, 1'b1, "R3");
      drain();
      rdy_aux = 1'b0;
      step(4);
      c = cyc;
      expect_at(c + 1, 1'b1, "R5");
      expect_at(c + 2, 1'b0, "R5");
      step(1);
      wait_clr = 1'b1;
      step(1);
      wait_clr = 1'b0;
      drain();

      // R5: clear held while a ready edge is detected
      c = cyc;
      wait_clr = 1'b1;
      rdy_aux = 1'b1;
      expect_at(c + LAT, 1'b0, "R5");
      expect_at(c + LAT + 1, 1'b0, "R5");
      expect_at(c + LAT + 4, 1'b0, "R5");
      drain();
      wait_clr = 1'b0;
      rdy_aux = 1'b0;
      step(4);

      // R6: rising halt ignored, falling halt times a hold
      c = cyc;
      halt_ack = 1'b1;
      expect_at(c + LAT, 1'b0, "R6");
      expect_at(c + LAT + 4, 1'b0, "R6");
      drain();
      c = cyc;
      halt_ack = 1'b0;
      expect_at(c + LAT - 1, 1'b0, "R6");
      expect_at(c + LAT, 1'b1, "R6");
      expect_at(c + LAT + HOLD - 1, 1'b1, "R6");
      expect_at(c + LAT + HOLD, 1'b0, "R6");
      drain();

      // R7: power-on clear trailing edge (poc has been high since reset)
      c = cyc;
      poc = 1'b0;
      expect_at(c + LAT - 1, 1'b0, "R7");
      expect_at(c + LAT, 1'b1, "R7");
      expect_at(c + LAT + HOLD - 1, 1'b1, "R7");
      expect_at(c + LAT + HOLD, 1'b0, "R7");
      drain();

      // R9: retrigger during an active period
      poc = 1'b1;
      halt_ack = 1'b1;
      step(6);
      c = cyc;
      expect_at(c + 1, 1'b0, "R9");
      poc = 1'b0;
      expect_at(c + LAT, 1'b1, "R9");
      step(6);
      halt_ack = 1'b0;
      expect_at(c + LAT + HOLD, 1'b1, "R9");
      expect_at(c + 6 + LAT + HOLD - 1, 1'b1, "R9");
      expect_at(c + 6 + LAT + HOLD, 1'b0, "R9");
      drain();

      // R8: panel reset blocked by strap low
      panel_rst_en = 1'b0;
      panel_rst = 1'b1;
      step(6);
      c = cyc;
      panel_rst = 1'b0;
      expect_at(c + LAT, 1'b0, "R8");
      expect_at(c + LAT + 3, 1'b0, "R8");
      expect_at(c + LAT + 8, 1'b0, "R8");
      drain();
      // R8: strap high lets it through
      panel_rst_en = 1'b1;
      panel_rst = 1'b1;
      step(6);
      c = cyc;
      panel_rst = 1'b0;
      expect_at(c + LAT, 1'b1, "R8");
      expect_at(c + LAT + HOLD - 1, 1'b1, "R8");
      expect_at(c + LAT + HOLD, 1'b0, "R8");
      drain();

      // R10: latch and timer together, latch cleared mid-hold
      halt_ack = 1'b1;
      step(6);
      c = cyc;
      rdy_main = 1'b1;
      halt_ack = 1'b0;
      expect_at(c + LAT, 1'b1, "R10");
      step(5);
      cycle_start = 1'b1;
      step(1);
      cycle_start = 1'b0;
      expect_at(c + 8, 1'b1, "R10");
      expect_at(c + LAT + HOLD - 1, 1'b1, "R10");
      expect_at(c + LAT + HOLD, 1'b0, "R10");
      drain();
      rdy_main = 1'b0;
      step(2);

      finish_run();
   end

endmodule